// File: doc/BRIEF.md
# Parallel Priority Interrupt Controller

Four interrupt sources each latch a request into their own bit of a pending register. A programmable mask decides which pending bits may take part in arbitration. Among the unmasked pending bits, the lowest index wins. A status flip-flop records that at least one unmasked request is waiting. A global enable flip-flop works with it, and together they drive a single interrupt line to the processor.

When the processor acknowledges, the controller drives a vector. The upper part of the vector comes from a programmable base register. The winner's two-bit index fills the lowest bits. Taking an acknowledge clears the winning pending bit and clears the enable flip-flop, so software has to re-enable before a further interrupt can be raised.

The vector drive is modelled as a separate output-enable signal. When that enable is low, the vector bus reads zero.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held and right after it, the pending bits, mask, base and enable are all zero, so `cpu_irq`, `vec_oe` and `vec_out` read 0.
- R2: A 1 on `src_req[i]` sets pending bit i at the next clock edge without touching the other bits, and the bit stays set until it is serviced.
- R3: Pending bit i takes part in arbitration only while mask bit i is 1. A masked request stays pending. It neither raises `cpu_irq` nor wins, and it competes again once it is unmasked. `mask_wr` loads `mask_wdata` into the mask at the clock edge.
- R4: Among the unmasked pending bits, index 0 has the highest priority and index 3 the lowest. `vec_out[1:0]` carries the winner's index as a binary number.
- R5: `vec_out[7:2]` carries the base register, which `base_wr` loads from `base_wdata` at the clock edge.
- R6: The status flip-flop is 1 exactly when some unmasked request is pending, and this includes a mask change that takes effect at the same edge. `cpu_irq` is the status flip-flop ANDed with the enable flip-flop.
- R7: `vec_oe` is 1 only in a cycle where `int_ack`, the status flip-flop and the enable flip-flop are all 1. While `vec_oe` is 0, `vec_out` is 0 and nothing is serviced.
- R8: A taken acknowledge (a cycle with `vec_oe` = 1) clears only the winning pending bit, at the clock edge that ends that cycle.
- R9: A taken acknowledge clears the enable flip-flop. A 1 on `ien_set` in the same cycle is ignored. In any other cycle, `ien_set` sets the enable flip-flop at the next edge.
- R10: If the source that is being cleared by a taken acknowledge requests again in that same cycle, its pending bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 4 | Per-source request, one bit per device |
| mask_wr | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 4 | New mask value, 1 = source allowed |
| base_wr | input | 1 | Write strobe for the vector base register |
| base_wdata | input | 6 | New vector base (upper vector bits) |
| ien_set | input | 1 | Software re-enable of the global enable flip-flop |
| int_ack | input | 1 | Interrupt acknowledge from the processor |
| cpu_irq | output | 1 | Interrupt request line to the processor |
| vec_out | output | 8 | Vector: base above, winner index in bits 1:0 |
| vec_oe | output | 1 | Vector drive enable (models the tristate buffer) |

## Verification
In a single cycle, servicing a winner can meet a fresh request from that same source, and the automatic clearing of the enable can meet a software re-enable. The bench provokes both at once: it raises `int_ack`, the winner's `src_req` bit and `ien_set` together. It then judges the outcome only at the ports. `cpu_irq` must fall, which shows the clear took priority over the re-enable. After a later re-enable, the line must rise again and the next acknowledge must return that same source's index, which shows the pending bit survived.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int unsigned DEF_NSRC  = 4;
    localparam int unsigned DEF_VEC_W = 8;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned NSRC = 4,
    parameter int unsigned IW   = 2
) (
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] grant,
    output logic [IW-1:0]   idx,
    output logic            any
);
    logic [NSRC-1:0] lower_hit;

    assign lower_hit[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < NSRC; g++) begin : g_prefix
            assign lower_hit[g] = lower_hit[g-1] | req[g-1];
        end
        for (g = 0; g < NSRC; g++) begin : g_grant
            assign grant[g] = req[g] & ~lower_hit[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end

    assign any = |req;

    // R4: at most one source may win
    always_comb begin
        if (!$isunknown(req)) begin
            p_grant_onehot_r4: assert ($onehot0(grant))
                else $error("R4 grant not one-hot");
        end
    end
endmodule

// File: rtl/irq_vec_gate.sv
module irq_vec_gate #(
    parameter int unsigned BASE_W = 6,
    parameter int unsigned IW     = 2
) (
    input  logic              ack,
    input  logic              ist,
    input  logic              ien,
    input  logic [BASE_W-1:0] base,
    input  logic [IW-1:0]     idx,
    output logic [BASE_W+IW-1:0] vec,
    output logic              oe
);
    always_comb begin
        oe  = ack & ist & ien;
        vec = oe ? {base, idx} : '0;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int unsigned NSRC  = DEF_NSRC,
    parameter int unsigned VEC_W = DEF_VEC_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              src_req,
    input  logic                         mask_wr,
    input  logic [NSRC-1:0]              mask_wdata,
    input  logic                         base_wr,
    input  logic [VEC_W-idx_width(NSRC)-1:0] base_wdata,
    input  logic                         ien_set,
    input  logic                         int_ack,
    output logic                         cpu_irq,
    output logic [VEC_W-1:0]             vec_out,
    output logic                         vec_oe
);
    localparam int unsigned IW     = idx_width(NSRC);
    localparam int unsigned BASE_W = VEC_W - IW;

    typedef struct packed {
        logic [NSRC-1:0]   pend;
        logic [NSRC-1:0]   mask;
        logic [BASE_W-1:0] base;
        logic              ist;
        logic              ien;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NSRC-1:0] live;
    logic [NSRC-1:0] grant;
    logic [IW-1:0]   win_idx;
    logic            live_any;
    logic            ack_take;
    logic [NSRC-1:0] clr_mask;

    assign live = st_q.pend & st_q.mask;

    irq_prio_enc #(.NSRC(NSRC), .IW(IW)) i_enc (
        .req   (live),
        .grant (grant),
        .idx   (win_idx),
        .any   (live_any)
    );

    irq_vec_gate #(.BASE_W(BASE_W), .IW(IW)) i_gate (
        .ack  (int_ack),
        .ist  (st_q.ist),
        .ien  (st_q.ien),
        .base (st_q.base),
        .idx  (win_idx),
        .vec  (vec_out),
        .oe   (vec_oe)
    );

    always_comb begin
        st_d     = st_q;
        ack_take = vec_oe;
        clr_mask = ack_take ? grant : '0;
        st_d.pend = (st_q.pend & ~clr_mask) | src_req;
        if (mask_wr) st_d.mask = mask_wdata;
        if (base_wr) st_d.base = base_wdata;
        st_d.ist = |(st_d.pend & st_d.mask);
        if (ack_take)     st_d.ien = 1'b0;
        else if (ien_set) st_d.ien = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_irq = st_q.ist & st_q.ien;

    // R6: status flop agrees with the encoder's view of live requests
    p_status_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ist == live_any)
        else $error("R6 status flop mismatch");

    // R7: vector drive only under acknowledge with a raised line
    p_oe_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (int_ack && cpu_irq))
        else $error("R7 vector driven without acknowledge");

    // R9: a taken acknowledge drops the request line next cycle
    p_ack_drops_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |=> !cpu_irq)
        else $error("R9 enable not cleared by acknowledge");

    // R8: serviced bit is cleared unless re-requested
    p_winner_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && !src_req[win_idx]) |=> !st_q.pend[$past(win_idx)])
        else $error("R8 serviced bit still pending");

    // R2: a request is pending at the following edge
    p_req_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        src_req[0] |=> st_q.pend[0])
        else $error("R2 request not latched");
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 4;
    localparam int VW   = 8;
    localparam int BW   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NSRC-1:0] src_req = '0;
    logic          mask_wr = 1'b0;
    logic [NSRC-1:0] mask_wdata = '0;
    logic          base_wr = 1'b0;
    logic [BW-1:0] base_wdata = '0;
    logic          ien_set = 1'b0;
    logic          int_ack = 1'b0;
    logic          cpu_irq;
    logic [VW-1:0] vec_out;
    logic          vec_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [BW-1:0] base_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .base_wr(base_wr), .base_wdata(base_wdata),
        .ien_set(ien_set), .int_ack(int_ack),
        .cpu_irq(cpu_irq), .vec_out(vec_out), .vec_oe(vec_oe)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_req(input logic [NSRC-1:0] v);
        src_req = v; step(); src_req = '0;
    endtask

    task automatic enable();
        ien_set = 1'b1; step(); ien_set = 1'b0;
    endtask

    task automatic set_mask(input logic [NSRC-1:0] m);
        mask_wr = 1'b1; mask_wdata = m; step(); mask_wr = 1'b0;
    endtask

    task automatic set_base(input logic [BW-1:0] b);
        base_wr = 1'b1; base_wdata = b; base_val = b; step(); base_wr = 1'b0;
    endtask

    task automatic take_ack(input string rq, input int exp_idx);
        int_ack = 1'b1; #1;
        chk({rq, " oe"}, 32'(vec_oe), 32'd1);
        chk({rq, " vec"}, 32'(vec_out), 32'({base_val, 2'(exp_idx)}));
        step(); int_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step();
        chk("R1 irq in reset", 32'(cpu_irq), 0);
        chk("R1 oe in reset", 32'(vec_oe), 0);
        rst_n = 1'b1; step();
        int_ack = 1'b1; #1;
        chk("R1 vec after reset", 32'(vec_out), 0);
        chk("R1 oe after reset", 32'(vec_oe), 0);
        int_ack = 1'b0;
        pulse_req(4'b0001);
        chk("R1 mask zero blocks irq", 32'(cpu_irq), 0);
        rst_n = 1'b0; step(); rst_n = 1'b1; step();
    endtask

    task automatic t_basic();
        set_base(6'h2A);
        set_mask(4'hF);
        enable();
        chk("R6 idle no irq", 32'(cpu_irq), 0);
        pulse_req(4'b0100);
        chk("R2 R6 irq raised", 32'(cpu_irq), 1);
        take_ack("R4 R5 R7 source2", 2);
        chk("R9 irq dropped after ack", 32'(cpu_irq), 0);
        pulse_req(4'b0001);
        chk("R9 no irq until re-enable", 32'(cpu_irq), 0);
        int_ack = 1'b1; #1;
        chk("R7 no oe while disabled", 32'(vec_oe), 0);
        chk("R7 vec zero while disabled", 32'(vec_out), 0);
        step(); int_ack = 1'b0;
        enable();
        chk("R7 request kept after ignored ack", 32'(cpu_irq), 1);
        take_ack("R4 source0", 0);
        enable();
        chk("R8 nothing left pending", 32'(cpu_irq), 0);
        int_ack = 1'b1; #1;
        chk("R7 no oe without pending", 32'(vec_oe), 0);
        step(); int_ack = 1'b0;
        pulse_req(4'b1000);
        chk("R9 enable kept by untaken ack", 32'(cpu_irq), 1);
        take_ack("R4 source3", 3);
    endtask

    task automatic t_priority();
        set_base(6'h11);
        pulse_req(4'b1010);
        enable();
        take_ack("R4 1 beats 3", 1);
        enable();
        chk("R8 source3 still pending", 32'(cpu_irq), 1);
        take_ack("R8 source3 next", 3);
        pulse_req(4'b1111);
        enable();
        take_ack("R4 all four -> 0", 0);
        enable(); take_ack("R4 then 1", 1);
        enable(); take_ack("R4 then 2", 2);
        enable(); take_ack("R4 then 3", 3);
        enable();
        chk("R8 all serviced", 32'(cpu_irq), 0);
    endtask

    task automatic t_mask();
        set_mask(4'b1110);
        pulse_req(4'b0001);
        chk("R3 masked source no irq", 32'(cpu_irq), 0);
        pulse_req(4'b0100);
        chk("R3 unmasked source irq", 32'(cpu_irq), 1);
        take_ack("R3 masked 0 skipped", 2);
        enable();
        chk("R3 masked pending silent", 32'(cpu_irq), 0);
        set_mask(4'hF);
        chk("R6 unmask raises irq", 32'(cpu_irq), 1);
        take_ack("R3 source0 after unmask", 0);
        enable();
    endtask

    task automatic t_collision();
        pulse_req(4'b0010);
        chk("R10 setup irq", 32'(cpu_irq), 1);
        int_ack = 1'b1; src_req = 4'b0010; ien_set = 1'b1; #1;
        chk("R10 oe in collision", 32'(vec_oe), 1);
        chk("R10 vec in collision", 32'(vec_out), 32'({base_val, 2'd1}));
        step();
        int_ack = 1'b0; src_req = '0; ien_set = 1'b0;
        chk("R9 set ignored during ack", 32'(cpu_irq), 0);
        enable();
        chk("R10 bit survived", 32'(cpu_irq), 1);
        take_ack("R10 same source again", 1);
        enable();
        chk("R10 cleared afterwards", 32'(cpu_irq), 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_priority();
        t_mask();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule